// File: doc/BRIEF.md
# Dual-Processor Failover Controller

This block supervises a pair of redundant processors that share one set of peripherals. Exactly one processor is in control at any time. A select output steers an external bus multiplexer so that only the controlling processor's bus reaches the peripherals. The block watches a voted error flag and the reset requests from each processor. When the controlling processor fails, or asks for a core reset, control passes to the standby processor.

A handover runs through a transition state that lasts one clock. In that clock the failed processor receives a core-reset pulse. The controller then brings the other processor online. A handover is held back while the shared bus is in the middle of a transfer, and it is remembered until the bus goes idle. Chip-level and system-level reset requests from the controlling processor are passed through as registered reset outputs. A saturating counter records how many handovers have taken place.

Inputs from the standby processor are never evaluated. The status output exposes the state code so that surrounding logic can follow the sequence.

Top module: `fovr_ctrl`

## Requirements
- R1: In the first cycle after a synchronous reset, the state code is 0 (processor A online), select is 0, the handover count is 0, and every reset output is low.
- R2: With processor A online and the bus idle, an error flag from A moves the state code to 2 (A-to-B transition) at the next clock edge, and to 1 (processor B online, select = 1) at the clock edge after that.
- R3: With processor B online and the bus idle, an error flag from B moves the state code to 3 (B-to-A transition) and then to 0, with select returning to 0.
- R4: A transition state lasts exactly one clock. During that clock and no other, the failed processor's core-reset output is high: bit 0 for A, bit 1 for B. The two bits are never high together.
- R5: A core-reset request from the controlling processor starts the same handover sequence as an error.
- R6: While a processor is online, its chip-reset or system-reset request shows on the matching reset output one clock later, and clears one clock after the request drops.
- R7: The error, core-reset, chip-reset and system-reset inputs of the standby processor have no effect on the state, the select output, the reset outputs or the count.
- R8: While bus-busy is high, no handover starts. A fault seen during that time is kept, and the transition state is entered at the first clock edge at which bus-busy is low.
- R9: The select output changes only on the edge that leaves a transition state and enters an online state (0 = A, 1 = B).
- R10: The handover count rises by exactly one each time an online state is entered from a transition state, and holds at its maximum value (2^CNT_W - 1) once reached.
- R11: In a transition state the chip-reset and system-reset outputs are held low in the next cycle, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | High while a bus transfer is in progress |
| proc_err | input | 2 | Voted error flag per processor (bit 0 = A, bit 1 = B) |
| proc_core_req | input | 2 | Core-reset request per processor |
| proc_chip_req | input | 2 | Chip-reset request per processor |
| proc_sys_req | input | 2 | System-reset request per processor |
| proc_sel | output | 1 | Multiplexer select: 0 = A, 1 = B |
| core_rst_pulse | output | 2 | Core-reset pulse to the failed processor |
| chip_rst | output | 1 | Forwarded chip reset |
| sys_rst | output | 1 | Forwarded system reset |
| fsm_state | output | 2 | State code: 0 A online, 1 B online, 2 A-to-B, 3 B-to-A |
| fail_count | output | CNT_W | Saturating handover count |

## Verification
The bench drives a fault while the bus is busy and then drops the fault. A design that did not remember the fault would never hand over, and a design that ignored bus-busy would switch in the middle of the transfer. Standby-processor inputs are held high for several cycles. A design that indexed the wrong processor would swap or forward a reset it should not. The handover count is pushed past its maximum, which shows any wraparound to zero. Every handover is sampled cycle by cycle, so a transition state that lasts too long, or a select that changes early, shows up at once.

// File: rtl/fovr_pkg.sv
package fovr_pkg;

    localparam int NPROC = 2;

    typedef enum logic [1:0] {
        ST_ON_A  = 2'd0,
        ST_ON_B  = 2'd1,
        ST_SW_AB = 2'd2,
        ST_SW_BA = 2'd3
    } fo_state_e;

    typedef struct packed {
        logic err;
        logic core;
        logic chip;
        logic sys;
    } fo_req_s;

    // Online states have bit 1 clear.
    function automatic logic is_online(fo_state_e s);
        return !s[1];
    endfunction

    // In an online state bit 0 names the controlling processor.
    // In a transition state bit 0 names the processor being retired.
    function automatic logic owner_idx(fo_state_e s);
        return s[0];
    endfunction

endpackage

// File: rtl/fovr_gate.sv
module fovr_gate
    import fovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fo_state_e        st,
    input  logic             bus_busy,
    input  logic [NPROC-1:0] err_i,
    input  logic [NPROC-1:0] core_i,
    input  logic [NPROC-1:0] chip_i,
    input  logic [NPROC-1:0] sys_i,
    output logic             go,
    output logic             chip_fwd,
    output logic             sys_fwd
);
    fo_req_s req_a [NPROC];
    fo_req_s act;
    logic    online;
    logic    fault;
    logic    pend_q;

    for (genvar p = 0; p < NPROC; p++) begin : g_pack
        assign req_a[p] = '{err: err_i[p], core: core_i[p],
                            chip: chip_i[p], sys: sys_i[p]};
    end

    always_comb begin
        act      = req_a[owner_idx(st)];
        online   = is_online(st);
        fault    = online && (act.err || act.core);
        go       = online && (fault || pend_q) && !bus_busy;
        chip_fwd = online && act.chip;
        sys_fwd  = online && act.sys;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= online && !go && (pend_q || fault);
    end
endmodule

// File: rtl/fovr_fsm.sv
module fovr_fsm
    import fovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output fo_state_e        st,
    output logic             sel,
    output logic [NPROC-1:0] core_rst
);
    fo_state_e st_q, nxt;
    logic      sel_q;
    logic [NPROC-1:0] core_q;

    always_comb begin
        unique case (st_q)
            ST_ON_A:  nxt = go ? ST_SW_AB : ST_ON_A;
            ST_ON_B:  nxt = go ? ST_SW_BA : ST_ON_B;
            ST_SW_AB: nxt = ST_ON_B;
            default:  nxt = ST_ON_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_ON_A;
            sel_q <= 1'b0;
        end else begin
            st_q <= nxt;
            if (is_online(nxt)) sel_q <= owner_idx(nxt);
        end
    end

    for (genvar p = 0; p < NPROC; p++) begin : g_crst
        always_ff @(posedge clk) begin
            if (rst) core_q[p] <= 1'b0;
            else     core_q[p] <= !is_online(nxt) && (owner_idx(nxt) == 1'(p));
        end
    end

    assign st       = st_q;
    assign sel      = sel_q;
    assign core_rst = core_q;
endmodule

// File: rtl/fovr_sat_cnt.sv
module fovr_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (inc && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/fovr_rst_fwd.sv
module fovr_rst_fwd (
    input  logic clk,
    input  logic rst,
    input  logic chip_fwd,
    input  logic sys_fwd,
    output logic chip_rst,
    output logic sys_rst
);
    logic chip_q, sys_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_q <= 1'b0;
            sys_q  <= 1'b0;
        end else begin
            chip_q <= chip_fwd;
            sys_q  <= sys_fwd;
        end
    end

    assign chip_rst = chip_q;
    assign sys_rst  = sys_q;
endmodule

// File: rtl/fovr_ctrl.sv
module fovr_ctrl
    import fovr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_busy,
    input  logic [1:0]       proc_err,
    input  logic [1:0]       proc_core_req,
    input  logic [1:0]       proc_chip_req,
    input  logic [1:0]       proc_sys_req,
    output logic             proc_sel,
    output logic [1:0]       core_rst_pulse,
    output logic             chip_rst,
    output logic             sys_rst,
    output logic [1:0]       fsm_state,
    output logic [CNT_W-1:0] fail_count
);
    fo_state_e st;
    logic      go, chip_fwd, sys_fwd;

    fovr_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .bus_busy (bus_busy),
        .err_i    (proc_err),
        .core_i   (proc_core_req),
        .chip_i   (proc_chip_req),
        .sys_i    (proc_sys_req),
        .go       (go),
        .chip_fwd (chip_fwd),
        .sys_fwd  (sys_fwd)
    );

    fovr_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .st       (st),
        .sel      (proc_sel),
        .core_rst (core_rst_pulse)
    );

    // The count moves on the edge that leaves a transition state.
    fovr_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (!is_online(st)),
        .cnt (fail_count)
    );

    fovr_rst_fwd u_fwd (
        .clk      (clk),
        .rst      (rst),
        .chip_fwd (chip_fwd),
        .sys_fwd  (sys_fwd),
        .chip_rst (chip_rst),
        .sys_rst  (sys_rst)
    );

    assign fsm_state = st;
endmodule

// File: rtl/fovr_ctrl_chk.sv
module fovr_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_busy,
    input logic [1:0]       proc_chip_req,
    input logic             proc_sel,
    input logic [1:0]       core_rst_pulse,
    input logic             chip_rst,
    input logic [1:0]       fsm_state,
    input logic [CNT_W-1:0] fail_count
);
    assert_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fsm_state == 2'd0 && !proc_sel && fail_count == '0));

    assert_ab_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        fsm_state == 2'd2 |=> fsm_state == 2'd1);

    assert_ba_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        fsm_state == 2'd3 |=> fsm_state == 2'd0);

    assert_core_pulse_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_rst_pulse));

    assert_core_pulse_in_switch_R4: assert property (@(posedge clk) disable iff (rst)
        (core_rst_pulse != 2'b00) |-> fsm_state[1]);

    assert_chip_forward_R6: assert property (@(posedge clk) disable iff (rst)
        (!fsm_state[1] && proc_chip_req[fsm_state[0]]) |=> chip_rst);

    assert_no_switch_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (!fsm_state[1] && bus_busy) |=> !fsm_state[1]);

    assert_sel_on_entry_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(proc_sel) |-> $past(fsm_state[1]));

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(fail_count) |-> (fail_count == $past(fail_count) + 1'b1));

    assert_no_reset_in_switch_R11: assert property (@(posedge clk) disable iff (rst)
        fsm_state[1] |=> !chip_rst);
endmodule

bind fovr_ctrl fovr_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_busy       (bus_busy),
    .proc_chip_req  (proc_chip_req),
    .proc_sel       (proc_sel),
    .core_rst_pulse (core_rst_pulse),
    .chip_rst       (chip_rst),
    .fsm_state      (fsm_state),
    .fail_count     (fail_count)
);

// File: tb/fovr_ctrl_tb.sv
`timescale 1ns/1ps
module fovr_ctrl_tb_top;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_busy = 1'b0;
    logic [1:0] proc_err = '0, proc_core_req = '0, proc_chip_req = '0, proc_sys_req = '0;
    logic proc_sel, chip_rst, sys_rst;
    logic [1:0] core_rst_pulse, fsm_state;
    logic [CNT_W-1:0] fail_count;

    int total = 0;
    int fails = 0;
    int exp_cnt = 0;
    int side = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fovr_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .bus_busy(bus_busy),
        .proc_err(proc_err), .proc_core_req(proc_core_req),
        .proc_chip_req(proc_chip_req), .proc_sys_req(proc_sys_req),
        .proc_sel(proc_sel), .core_rst_pulse(core_rst_pulse),
        .chip_rst(chip_rst), .sys_rst(sys_rst),
        .fsm_state(fsm_state), .fail_count(fail_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic bump();
        if (exp_cnt < CMAX) exp_cnt++;
    endtask

    task automatic t_reset();
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 state", fsm_state, 0);
        chk("R1 sel", proc_sel, 0);
        chk("R1 count", fail_count, 0);
        chk("R1 core rst", core_rst_pulse, 0);
        chk("R1 chip/sys", {chip_rst, sys_rst}, 0);
    endtask

    task automatic t_fail_a();
        proc_err[0] = 1'b1;
        step();
        proc_err[0] = 1'b0;
        chk("R2 state A-to-B", fsm_state, 2);
        chk("R4 core pulse A", core_rst_pulse, 1);
        chk("R9 sel held in switch", proc_sel, 0);
        chk("R10 count before entry", fail_count, exp_cnt);
        step();
        bump(); side = 1;
        chk("R2 state B online", fsm_state, 1);
        chk("R2 sel B", proc_sel, 1);
        chk("R4 pulse ends", core_rst_pulse, 0);
        chk("R10 count", fail_count, exp_cnt);
    endtask

    task automatic t_fail_b();
        proc_err[1] = 1'b1;
        step();
        proc_err[1] = 1'b0;
        chk("R3 state B-to-A", fsm_state, 3);
        chk("R4 core pulse B", core_rst_pulse, 2);
        chk("R9 sel held in switch", proc_sel, 1);
        step();
        bump(); side = 0;
        chk("R3 state A online", fsm_state, 0);
        chk("R3 sel A", proc_sel, 0);
        chk("R10 count", fail_count, exp_cnt);
    endtask

    task automatic t_core_swap();
        proc_core_req[0] = 1'b1;
        step();
        proc_core_req[0] = 1'b0;
        chk("R5 core req A starts switch", fsm_state, 2);
        step();
        bump();
        chk("R5 B online", fsm_state, 1);
        proc_core_req[1] = 1'b1;
        step();
        proc_core_req[1] = 1'b0;
        chk("R5 core req B starts switch", fsm_state, 3);
        chk("R5 pulse to B", core_rst_pulse, 2);
        step();
        bump(); side = 0;
        chk("R5 A online", fsm_state, 0);
        chk("R10 count", fail_count, exp_cnt);
    endtask

    task automatic t_standby();
        proc_err[1] = 1'b1; proc_core_req[1] = 1'b1;
        proc_chip_req[1] = 1'b1; proc_sys_req[1] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 state", fsm_state, 0);
            chk("R7 sel", proc_sel, 0);
            chk("R7 resets", {core_rst_pulse, chip_rst, sys_rst}, 0);
        end
        proc_err[1] = 1'b0; proc_core_req[1] = 1'b0;
        proc_chip_req[1] = 1'b0; proc_sys_req[1] = 1'b0;
        step();
        chk("R7 count", fail_count, exp_cnt);
    endtask

    task automatic t_rst_fwd();
        proc_chip_req[0] = 1'b1;
        step();
        chk("R6 chip on", chip_rst, 1);
        chk("R6 sys off", sys_rst, 0);
        proc_chip_req[0] = 1'b0; proc_sys_req[0] = 1'b1;
        step();
        chk("R6 chip off", chip_rst, 0);
        chk("R6 sys on", sys_rst, 1);
        proc_sys_req[0] = 1'b0;
        step();
        chk("R6 sys off", sys_rst, 0);
        chk("R6 no swap", fsm_state, 0);
    endtask

    task automatic t_switch_blocks_reset();
        proc_err[0] = 1'b1; proc_chip_req[0] = 1'b1;
        step();
        proc_err[0] = 1'b0;
        chk("R11 chip from online", chip_rst, 1);
        chk("R11 in switch", fsm_state, 2);
        step();
        proc_chip_req[0] = 1'b0;
        bump(); side = 1;
        chk("R11 chip low after switch", chip_rst, 0);
        chk("R11 B online", fsm_state, 1);
    endtask

    task automatic t_busy();
        bus_busy = 1'b1;
        proc_err[1] = 1'b1;
        step();
        proc_err[1] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R8 held while busy", fsm_state, 1);
            chk("R9 sel steady", proc_sel, 1);
            step();
        end
        bus_busy = 1'b0;
        step();
        chk("R8 switch after idle", fsm_state, 3);
        step();
        bump(); side = 0;
        chk("R8 A online", fsm_state, 0);
        chk("R10 count", fail_count, exp_cnt);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 14; k++) begin
            proc_err[side] = 1'b1;
            step();
            proc_err = '0;
            step();
            bump(); side = 1 - side;
            chk("R10 count step", fail_count, exp_cnt);
            chk("R9 sel side", proc_sel, side);
        end
        chk("R10 saturated", fail_count, CMAX);
    endtask

    initial begin
        t_reset();
        t_fail_a();
        t_fail_b();
        t_core_swap();
        t_standby();
        t_rst_fwd();
        t_switch_blocks_reset();
        t_busy();
        t_saturate();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            report();
            $finish;
        end
    end
endmodule